// File: doc/BRIEF.md
# Big-Endian Card Bus Sizing Sequencer

This block sits between a 32-bit internal request port and a PC-card style external bus whose data path is 16 or 8 bits wide. It accepts one access of one to four bytes, given a size code, a two-bit byte offset, a direction and right-aligned write data. It breaks the access into the external cycles that the selected port width needs. For every cycle it drives the low address bits, two active-low byte-lane selects and the data lanes. On a read it collects the returned bytes into a 32-bit result.

Byte order is big endian. The byte at the lowest address is the most significant byte of the access's data field. Each external cycle is an abstract request/acknowledge handshake, so card timing lives outside the block. The port width is a runtime input and is captured when a request is accepted. A request whose byte span would run past the 4-byte boundary is refused, and no external cycle is issued for it.

Top module: `card_size_seq`

## Requirements
- R1: `req_size_i` codes 0, 1, 2 and 3 mean 1, 2, 3 and 4 bytes, covering the addresses from `req_offset_i` upward. If offset plus byte count exceeds 4, then in the cycle after acceptance `err_o` pulses for one cycle, no external cycle is issued and `req_ready_o` stays high.
- R2: `req_ready_o` is high while idle, and a request is taken when `req_valid_i` and `req_ready_o` are both high. Ready stays low from acceptance until the cycle after the last acknowledge. In that cycle `done_o` pulses for exactly one cycle while ready is high again.
- R3: On a 16-bit port (`port8_i`=0), one external cycle is issued per 2-byte half that holds a covered byte: address 00 first, then 10. `ext_addr_o[0]` is 0. This gives two cycles for a word or a three-byte access, and one cycle for a byte or an aligned half-word.
- R4: An n-byte access uses `req_wdata_i[8n-1:0]`, and its lowest-addressed byte is the most significant byte of that field. On a 16-bit port, the byte at an even address moves on `ext_wdata_o[15:8]` and the byte at an odd address on `ext_wdata_o[7:0]`. Lanes without a covered byte, and all lanes during reads, carry zero.
- R5: On a 16-bit port, `ext_cs_hi_no` selects lane [15:8] and `ext_cs_lo_no` selects lane [7:0]. Both are active low, and only the lanes carrying covered bytes are asserted.
- R6: On an 8-bit port (`port8_i`=1), one cycle is issued per covered byte in ascending address order. `ext_addr_o` is the byte address, the byte moves on lane [7:0] with [15:8] at zero, and every cycle has `ext_cs_hi_no`=1 and `ext_cs_lo_no`=0. On reads only `ext_rdata_i[7:0]` is used.
- R7: In the `done_o` cycle, `rdata_o` holds the read bytes right-aligned with the byte order of R4, and all bits not covered by the access are zero. After a write it is zero.
- R8: `ext_req_o` is held with stable address, selects, write data and direction until `ext_ack_i` is sampled high.
- R9: The port width is sampled when a request is accepted. Changes of `port8_i` during an access have no effect on that access.
- R10: `ext_we_o` is high for every cycle of a write and low for every cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Byte count minus one |
| req_offset_i | input | 2 | Byte offset of the lowest-addressed byte |
| req_wdata_i | input | 32 | Right-aligned write data |
| port8_i | input | 1 | 1 = 8-bit port, 0 = 16-bit port |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle refusal pulse |
| rdata_o | output | 32 | Assembled read result, valid with done_o |
| ext_req_o | output | 1 | External cycle request |
| ext_ack_i | input | 1 | External cycle acknowledge |
| ext_we_o | output | 1 | External cycle direction |
| ext_addr_o | output | 2 | External low address bits |
| ext_cs_hi_no | output | 1 | Upper lane select, active low |
| ext_cs_lo_no | output | 1 | Lower lane select, active low |
| ext_wdata_o | output | 16 | External write lanes |
| ext_rdata_i | input | 16 | External read lanes |

## Verification
Some properties are checked on every clock cycle:
- the held request with stable address, selects and data while no acknowledge has arrived;
- that at least one lane select is asserted in every cycle, and that a cycle using both lanes sits at an even address;
- that an accepted request leads either to a refusal pulse or to an external request;
- that the completion pulse follows an acknowledge;
- that a refusal never coincides with external activity.

Only the bench scenarios can show the rest. The scoreboard compares every cycle against the expected sequence, which covers cycle counts, addresses, lane placement, big-endian byte order and read assembly with zeroed uncovered bytes. It also covers the 8-bit select pattern and the port width staying fixed when `port8_i` toggles during an access.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
  localparam int unsigned NBYTE  = 4;
  localparam int unsigned BW     = 8;
  localparam int unsigned DW     = NBYTE * BW;
  localparam int unsigned OFFW   = $clog2(NBYTE);
  localparam int unsigned EDW    = 2 * BW;

  // index 0 is the lowest address and the most significant byte
  typedef logic [0:NBYTE-1][BW-1:0] byte_vec_t;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_TRIPLE, SZ_WORD} size_e;
  typedef enum logic {ST_IDLE, ST_RUN} state_e;
endpackage

// File: rtl/csz_decode.sv
module csz_decode
  import card_seq_pkg::*;
(
  input  logic [1:0]      size_i,
  input  logic [OFFW-1:0] offset_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [NBYTE-1:0] mask_o,
  output logic            err_o,
  output logic [OFFW-1:0] shift_o,
  output byte_vec_t       aligned_o
);
  localparam int unsigned CW = OFFW + 1;

  logic [CW-1:0] cnt, span_end, pad;

  assign cnt      = CW'(size_i) + CW'(1);
  assign span_end = CW'(offset_i) + cnt;
  assign err_o    = span_end > CW'(NBYTE);
  assign pad      = CW'(NBYTE) - span_end;
  assign shift_o  = pad[OFFW-1:0];
  assign aligned_o = byte_vec_t'(wdata_i << {shift_o, 3'b000});

  for (genvar a = 0; a < NBYTE; a++) begin : g_mask
    assign mask_o[a] = (CW'(a) >= CW'(offset_i)) && (CW'(a) < span_end);
  end
endmodule

// File: rtl/csz_lanes.sv
module csz_lanes
  import card_seq_pkg::*;
(
  input  logic [NBYTE-1:0] pend_i,
  input  logic             port8_i,
  input  logic             write_i,
  input  byte_vec_t        buf_i,
  output logic [OFFW-1:0]  addr_o,
  output logic [NBYTE-1:0] act_o,
  output logic             cs_hi_no,
  output logic             cs_lo_no,
  output logic [EDW-1:0]   wdata_o
);
  logic [OFFW-1:0] first;
  logic [OFFW-1:0] even_a, odd_a;
  logic            half;

  always_comb begin
    first = '0;
    for (int i = NBYTE - 1; i >= 0; i--) begin
      if (pend_i[i]) first = OFFW'(i);
    end
  end

  assign half   = first[1];
  assign even_a = {half, 1'b0};
  assign odd_a  = {half, 1'b1};

  always_comb begin
    if (port8_i) begin
      act_o    = NBYTE'(1) << first;
      addr_o   = first;
      cs_hi_no = 1'b1;
      cs_lo_no = 1'b0;
      wdata_o  = {{BW{1'b0}}, write_i ? buf_i[first] : {BW{1'b0}}};
    end else begin
      act_o    = pend_i & (half ? 4'b1100 : 4'b0011);
      addr_o   = even_a;
      cs_hi_no = !act_o[even_a];
      cs_lo_no = !act_o[odd_a];
      wdata_o[EDW-1:BW] = (write_i && act_o[even_a]) ? buf_i[even_a] : '0;
      wdata_o[BW-1:0]   = (write_i && act_o[odd_a])  ? buf_i[odd_a]  : '0;
    end
  end
endmodule

// File: rtl/csz_ctrl.sv
module csz_ctrl
  import card_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             write_i,
  input  logic             port8_i,
  input  logic             dec_err_i,
  input  logic [NBYTE-1:0] dec_mask_i,
  input  logic [OFFW-1:0]  dec_shift_i,
  input  byte_vec_t        dec_aligned_i,
  input  logic             ack_i,
  input  logic [NBYTE-1:0] act_i,
  input  logic [EDW-1:0]   ext_rdata_i,
  output logic             run_o,
  output logic             write_o,
  output logic             port8_o,
  output logic [NBYTE-1:0] pend_o,
  output byte_vec_t        buf_o,
  output logic             done_o,
  output logic             err_o,
  output logic [DW-1:0]    rdata_o
);
  state_e          state_q;
  logic [NBYTE-1:0] pend_q, pend_nxt;
  byte_vec_t       buf_q, buf_nxt;
  logic [OFFW-1:0] shift_q;
  logic            write_q, port8_q;

  assign pend_nxt = pend_q & ~act_i;

  always_comb begin
    buf_nxt = buf_q;
    for (int a = 0; a < NBYTE; a++) begin
      if (ack_i && act_i[a] && !write_q) begin
        if (port8_q || (a % 2) == 1) buf_nxt[a] = ext_rdata_i[BW-1:0];
        else                         buf_nxt[a] = ext_rdata_i[EDW-1:BW];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      buf_q   <= '0;
      shift_q <= '0;
      write_q <= 1'b0;
      port8_q <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take_i) begin
            if (dec_err_i) begin
              err_o <= 1'b1;
            end else begin
              state_q <= ST_RUN;
              pend_q  <= dec_mask_i;
              buf_q   <= write_i ? dec_aligned_i : '0;
              shift_q <= dec_shift_i;
              write_q <= write_i;
              port8_q <= port8_i;
            end
          end
        end
        ST_RUN: begin
          if (ack_i) begin
            pend_q <= pend_nxt;
            buf_q  <= buf_nxt;
            if (pend_nxt == '0) begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
              rdata_o <= write_q ? '0 : (DW'(buf_nxt) >> {shift_q, 3'b000});
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o   = (state_q == ST_RUN);
  assign write_o = write_q;
  assign port8_o = port8_q;
  assign pend_o  = pend_q;
  assign buf_o   = buf_q;
endmodule

// File: rtl/card_size_seq.sv
module card_size_seq
  import card_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [1:0]  req_size_i,
  input  logic [1:0]  req_offset_i,
  input  logic [31:0] req_wdata_i,
  input  logic        port8_i,
  output logic        done_o,
  output logic        err_o,
  output logic [31:0] rdata_o,
  output logic        ext_req_o,
  input  logic        ext_ack_i,
  output logic        ext_we_o,
  output logic [1:0]  ext_addr_o,
  output logic        ext_cs_hi_no,
  output logic        ext_cs_lo_no,
  output logic [15:0] ext_wdata_o,
  input  logic [15:0] ext_rdata_i
);
  logic [NBYTE-1:0] dec_mask, pend, act;
  logic             dec_err, run, write_q, port8_q;
  logic [OFFW-1:0]  dec_shift, lane_addr;
  byte_vec_t        dec_aligned, buf_q;
  logic             lane_hi_n, lane_lo_n;
  logic [EDW-1:0]   lane_wdata;

  csz_decode i_decode (
    .size_i   (req_size_i),
    .offset_i (req_offset_i),
    .wdata_i  (req_wdata_i),
    .mask_o   (dec_mask),
    .err_o    (dec_err),
    .shift_o  (dec_shift),
    .aligned_o(dec_aligned)
  );

  csz_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (req_valid_i && req_ready_o),
    .write_i      (req_write_i),
    .port8_i      (port8_i),
    .dec_err_i    (dec_err),
    .dec_mask_i   (dec_mask),
    .dec_shift_i  (dec_shift),
    .dec_aligned_i(dec_aligned),
    .ack_i        (ext_ack_i && run),
    .act_i        (act),
    .ext_rdata_i  (ext_rdata_i),
    .run_o        (run),
    .write_o      (write_q),
    .port8_o      (port8_q),
    .pend_o       (pend),
    .buf_o        (buf_q),
    .done_o       (done_o),
    .err_o        (err_o),
    .rdata_o      (rdata_o)
  );

  csz_lanes i_lanes (
    .pend_i  (pend),
    .port8_i (port8_q),
    .write_i (write_q),
    .buf_i   (buf_q),
    .addr_o  (lane_addr),
    .act_o   (act),
    .cs_hi_no(lane_hi_n),
    .cs_lo_no(lane_lo_n),
    .wdata_o (lane_wdata)
  );

  assign req_ready_o  = !run;
  assign ext_req_o    = run;
  assign ext_we_o     = run && write_q;
  assign ext_addr_o   = run ? lane_addr : '0;
  assign ext_cs_hi_no = run ? lane_hi_n : 1'b1;
  assign ext_cs_lo_no = run ? lane_lo_n : 1'b1;
  assign ext_wdata_o  = run ? lane_wdata : '0;
endmodule

// File: rtl/card_size_seq_chk.sv
module card_size_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        done_o,
  input logic        err_o,
  input logic        ext_req_o,
  input logic        ext_ack_i,
  input logic        ext_we_o,
  input logic [1:0]  ext_addr_o,
  input logic        ext_cs_hi_no,
  input logic        ext_cs_lo_no,
  input logic [15:0] ext_wdata_o
);
  a_r1_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!ext_req_o && req_ready_o && !done_o));

  a_r2_accept_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (ext_req_o || err_o));

  a_r2_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(ext_req_o && ext_ack_i));

  a_r5_some_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o |-> !(ext_cs_hi_no && ext_cs_lo_no));

  a_r5_pair_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_o && !ext_cs_hi_no && !ext_cs_lo_no) |-> (ext_addr_o[0] == 1'b0));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_o && !ext_ack_i) |=> (ext_req_o && $stable(ext_addr_o) &&
      $stable(ext_cs_hi_no) && $stable(ext_cs_lo_no) &&
      $stable(ext_wdata_o) && $stable(ext_we_o)));
endmodule

bind card_size_seq card_size_seq_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .ext_req_o   (ext_req_o),
  .ext_ack_i   (ext_ack_i),
  .ext_we_o    (ext_we_o),
  .ext_addr_o  (ext_addr_o),
  .ext_cs_hi_no(ext_cs_hi_no),
  .ext_cs_lo_no(ext_cs_lo_no),
  .ext_wdata_o (ext_wdata_o)
);

// File: tb/test_card_size_seq.sv
module test_card_size_seq;
  typedef struct packed {
    logic [1:0]  addr;
    logic        hi_n;
    logic        lo_n;
    logic        we;
    logic [15:0] wdata;
    logic        p8;
  } beat_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, port8 = 1'b0;
  logic [1:0] req_size = '0, req_offset = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, done, err, ext_req, ext_we, cs_hi_n, cs_lo_n;
  logic [31:0] rdata;
  logic [1:0] ext_addr;
  logic [15:0] ext_wdata, ext_rdata;
  logic ext_ack = 1'b0;

  logic [7:0] card_mem [0:3];
  logic cur_p8 = 1'b0;
  beat_t beat_q[$];
  logic [31:0] rd_q[$];
  int checks = 0, fails = 0;
  int beat_no = 0, wait_cnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  card_size_seq i_card_size_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_size_i(req_size), .req_offset_i(req_offset), .req_wdata_i(req_wdata),
    .port8_i(port8), .done_o(done), .err_o(err), .rdata_o(rdata),
    .ext_req_o(ext_req), .ext_ack_i(ext_ack), .ext_we_o(ext_we),
    .ext_addr_o(ext_addr), .ext_cs_hi_no(cs_hi_n), .ext_cs_lo_no(cs_lo_n),
    .ext_wdata_o(ext_wdata), .ext_rdata_i(ext_rdata)
  );

  always_comb begin
    if (cur_p8) ext_rdata = {8'hA5, card_mem[ext_addr]};
    else        ext_rdata = {card_mem[{ext_addr[1], 1'b0}], card_mem[{ext_addr[1], 1'b1}]};
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor and card responder
  always @(negedge clk) begin
    if (rst_n) begin
      if (ext_ack) begin
        ext_ack = 1'b0;
      end else if (ext_req) begin
        if (wait_cnt > 0) begin
          wait_cnt--;
        end else begin
          if (beat_q.size() == 0) begin
            check("R1 unexpected external cycle", 32'd1, 32'd0);
          end else begin
            beat_t e;
            e = beat_q.pop_front();
            check(e.p8 ? "R6 address" : "R3 address", 32'(ext_addr), 32'(e.addr));
            check(e.p8 ? "R6 selects" : "R5 selects", 32'({cs_hi_n, cs_lo_n}), 32'({e.hi_n, e.lo_n}));
            check(e.p8 ? "R6 write lanes" : "R4 write lanes", 32'(ext_wdata), 32'(e.wdata));
            check("R10 direction", 32'(ext_we), 32'(e.we));
          end
          ext_ack = 1'b1;
          beat_no++;
          wait_cnt = beat_no % 3;
        end
      end
      if (done) begin
        if (rd_q.size() == 0) check("R2 unexpected done", 32'd1, 32'd0);
        else check("R7 read result", rdata, rd_q.pop_front());
      end
    end
  end

  task automatic access(input bit wr, input logic [1:0] sz, input logic [1:0] off,
                        input logic [31:0] wd, input bit p8, input bit flip);
    int n, lim;
    bit bad;
    logic [31:0] exp_rd;
    beat_t b;
    n = int'(sz) + 1;
    bad = (int'(off) + n) > 4;
    exp_rd = '0;
    if (!bad) begin
      for (int k = 0; k < n; k++) exp_rd = (exp_rd << 8) | 32'(card_mem[int'(off) + k]);
      if (wr) exp_rd = '0;
      rd_q.push_back(exp_rd);
      if (p8) begin
        for (int a = int'(off); a < int'(off) + n; a++) begin
          b = '0; b.p8 = 1'b1; b.addr = 2'(a); b.hi_n = 1'b1; b.lo_n = 1'b0; b.we = wr;
          b.wdata = wr ? {8'h00, wd[8*(n-1-(a-int'(off))) +: 8]} : 16'h0;
          beat_q.push_back(b);
        end
      end else begin
        for (int h = 0; h < 2; h++) begin
          bit hc, lc;
          hc = (2*h >= int'(off)) && (2*h < int'(off) + n);
          lc = (2*h+1 >= int'(off)) && (2*h+1 < int'(off) + n);
          if (hc || lc) begin
            b = '0; b.addr = 2'(2*h); b.hi_n = !hc; b.lo_n = !lc; b.we = wr;
            if (wr && hc) b.wdata[15:8] = wd[8*(n-1-(2*h-int'(off))) +: 8];
            if (wr && lc) b.wdata[7:0]  = wd[8*(n-1-(2*h+1-int'(off))) +: 8];
            beat_q.push_back(b);
          end
        end
      end
    end
    cur_p8 = p8;
    req_valid = 1'b1; req_write = wr; req_size = sz; req_offset = off;
    req_wdata = wd; port8 = p8;
    check("R2 ready while idle", 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) port8 = !p8; // R9
    if (bad) begin
      check("R1 error pulse", 32'(err), 32'd1);
      check("R1 no external cycle", 32'(ext_req), 32'd0);
      check("R1 ready kept", 32'(req_ready), 32'd1);
      @(negedge clk);
      check("R1 error one cycle", 32'(err), 32'd0);
      check("R1 no external cycle later", 32'(ext_req), 32'd0);
    end else begin
      lim = 0;
      while (!done && lim < 60) begin
        check("R2 ready low while busy", 32'(req_ready), 32'd0);
        @(negedge clk);
        lim++;
      end
      check("R2 done reached", 32'(done), 32'd1);
      check("R2 ready with done", 32'(req_ready), 32'd1);
      check(p8 ? "R6 cycle count" : "R3 cycle count", 32'(beat_q.size()), 32'd0);
      @(negedge clk);
      check("R2 done one cycle", 32'(done), 32'd0);
    end
    port8 = p8;
  endtask

  task automatic load_mem(input logic [31:0] v);
    for (int i = 0; i < 4; i++) card_mem[i] = v[31-8*i -: 8];
  endtask

  initial begin
    load_mem(32'h11223344);
    repeat (3) @(negedge clk);
    check("R2 reset ready", 32'(req_ready), 32'd1);
    check("R2 reset done", 32'(done), 32'd0);
    check("R1 reset error", 32'(err), 32'd0);
    check("R8 reset request", 32'(ext_req), 32'd0);
    check("R5 reset selects", 32'({cs_hi_n, cs_lo_n}), 32'd3);
    rst_n = 1'b1;
    @(negedge clk);
    // 16-bit port
    access(1, 2'd3, 2'd0, 32'hA1B2C3D4, 0, 0);
    access(0, 2'd3, 2'd0, 32'h0, 0, 0);
    access(1, 2'd2, 2'd0, 32'h00CAFE01, 0, 0);
    access(1, 2'd2, 2'd1, 32'h00BEEF02, 0, 0);
    access(0, 2'd2, 2'd0, 32'h0, 0, 0);
    access(0, 2'd2, 2'd1, 32'h0, 0, 0);
    access(1, 2'd1, 2'd0, 32'h00005566, 0, 0);
    access(0, 2'd1, 2'd2, 32'h0, 0, 0);
    access(0, 2'd1, 2'd1, 32'h0, 0, 0);
    for (int o = 0; o < 4; o++) begin
      access(1, 2'd0, 2'(o), 32'h000000E0 + 32'(o), 0, 0);
      access(0, 2'd0, 2'(o), 32'h0, 0, 0);
    end
    // 8-bit port
    load_mem(32'h9A8B7C6D);
    access(1, 2'd3, 2'd0, 32'h01020304, 1, 0);
    access(0, 2'd3, 2'd0, 32'h0, 1, 0);
    access(1, 2'd1, 2'd2, 32'h0000ABCD, 1, 0);
    access(0, 2'd1, 2'd2, 32'h0, 1, 0);
    access(0, 2'd2, 2'd1, 32'h0, 1, 0);
    access(1, 2'd0, 2'd3, 32'h00000077, 1, 0);
    // R9 width changes mid-access
    access(0, 2'd3, 2'd0, 32'h0, 1, 1);
    access(1, 2'd3, 2'd0, 32'h55AA33CC, 0, 1);
    // R1 refused spans
    access(1, 2'd1, 2'd3, 32'h0000FFFF, 0, 0);
    access(0, 2'd3, 2'd1, 32'h0, 1, 0);
    access(1, 2'd2, 2'd2, 32'h00123456, 0, 0);
    access(0, 2'd0, 2'd2, 32'h0, 0, 0);
    repeat (4) @(negedge clk);
    check("R2 queue drained", 32'(rd_q.size() + beat_q.size()), 32'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule